// File: doc/BRIEF.md
# Stepped Soft-Start Setpoint Sequencer

This block produces the current-limit setpoint code that feeds a DAC while a power controller is starting. Each start pulse restarts a staircase at code zero. The staircase climbs in a fixed number of equal-time steps to full scale and then stays there until the next start. The time spent on each step is a parameter counted in clock ticks, so the whole soft-start lasts `NUM_STEPS * STEP_TICKS` cycles.

The feedback loop supplies its own setpoint code. The block passes on whichever of the two codes is lower. While the staircase is still below the loop's demand, the staircase sets the limit. Once the loop asks for less, the loop sets the limit. A stop input drops the staircase to zero at once. The staircase then stays idle until a new start arrives.

All three outputs are registered and change on the same clock edge.

Top module: `ssq_softstart`

## Requirements
- R1: During and directly after a synchronous reset, `ss_code_o`, `limit_code_o` and `done_o` are all 0.
- R2: When `start_i` is sampled high and `stop_i` is low, `ss_code_o` is 0 after that edge, whatever its previous value.
- R3: Step k of the staircase has code floor(k * (2^CODE_W - 1) / NUM_STEPS). With the defaults (8-bit code, 15 steps) this is 17*k. Each step holds for exactly STEP_TICKS clock edges, and the code never decreases except through a start or a stop.
- R4: The staircase has exactly NUM_STEPS rises. Full scale (255 by default) first appears NUM_STEPS*STEP_TICKS edges after the start edge (60 edges by default).
- R5: Once at full scale, `ss_code_o` stays at full scale until a start or a stop. `done_o` is 1 exactly while `ss_code_o` is at full scale.
- R6: After every edge, `limit_code_o` equals the smaller of `ss_code_o` and the `fb_code_i` value sampled at that edge.
- R7: When `stop_i` is sampled high, `ss_code_o` and `done_o` are 0 after that edge and stay 0 until a later start. Stop wins over a simultaneous start.
- R8: A start during the ramp or during the full-scale hold restarts the staircase from step 0.
- R9: Before the first start, `ss_code_o` and `limit_code_o` remain 0 for any `fb_code_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Controller start/restart pulse |
| stop_i | input | 1 | Stop/fault; clears the staircase |
| fb_code_i | input | CODE_W | Feedback-derived setpoint code |
| ss_code_o | output | CODE_W | Current soft-start staircase code |
| limit_code_o | output | CODE_W | Effective setpoint: lower of staircase and feedback |
| done_o | output | 1 | High while the staircase is at full scale |

## Verification
Four properties are checked on every cycle:
- the effective limit equals the minimum of the two setpoints;
- a stop or a start lands the staircase at zero;
- the staircase never falls between such events;
- the done flag tracks full scale.

Three behaviours depend on counting cycles since an event, so only the directed scenarios can show them:
- the exact code of each step;
- the dwell of each step in ticks;
- the total soft-start duration.

The scenarios also show that stop wins over a simultaneous start and that the block stays idle before its first start.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [1:0] {
    SSQ_IDLE = 2'd0,
    SSQ_RAMP = 2'd1,
    SSQ_HOLD = 2'd2
  } ssq_state_e;

  // Code of staircase step k for a given full-scale code and step count.
  function automatic int ssq_level(input int k, input int steps, input int full);
    return (k * full) / steps;
  endfunction

endpackage

// File: rtl/ssq_tick_div.sv
// Counts STEP_TICKS clock ticks per staircase step while enabled.
module ssq_tick_div #(
  parameter int STEP_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic step_o
);
  localparam int CW = (STEP_TICKS > 1) ? $clog2(STEP_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign step_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      cnt_q <= '0;
    end else if (step_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ssq_step_ctrl.sv
// Sequencer state and step index; exposes the next index for registered outputs.
module ssq_step_ctrl
  import ssq_pkg::*;
#(
  parameter int NUM_STEPS = 15,
  parameter int IW        = $clog2(NUM_STEPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          step_i,
  output logic          ramp_o,
  output logic [IW-1:0] idx_d_o
);
  localparam logic [IW-1:0] TOP = IW'(NUM_STEPS);

  ssq_state_e    state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (stop_i) begin
      state_d = SSQ_IDLE;
      idx_d   = '0;
    end else if (start_i) begin
      state_d = SSQ_RAMP;
      idx_d   = '0;
    end else if (state_q == SSQ_RAMP && step_i) begin
      idx_d = idx_q + 1'b1;
      if (idx_q + 1'b1 == TOP) begin
        state_d = SSQ_HOLD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SSQ_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign ramp_o  = (state_q == SSQ_RAMP);
  assign idx_d_o = idx_d;
endmodule

// File: rtl/ssq_level_rom.sv
// Computed step-to-code lookup, one constant per step.
module ssq_level_rom
  import ssq_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int NUM_STEPS = 15,
  parameter int IW        = $clog2(NUM_STEPS + 1)
) (
  input  logic [IW-1:0]     idx_i,
  output logic [CODE_W-1:0] level_o
);
  localparam int FULL = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] lut [NUM_STEPS+1];

  for (genvar k = 0; k <= NUM_STEPS; k++) begin : g_lvl
    localparam int LV = ssq_level(k, NUM_STEPS, FULL);
    assign lut[k] = LV[CODE_W-1:0];
  end

  always_comb begin
    if (int'(idx_i) <= NUM_STEPS) begin
      level_o = lut[idx_i];
    end else begin
      level_o = CODE_W'(FULL);
    end
  end
endmodule

// File: rtl/ssq_min_sel.sv
// Lower of two setpoint codes (ORed comparator equivalent).
module ssq_min_sel #(
  parameter int CODE_W = 8
) (
  input  logic [CODE_W-1:0] a_i,
  input  logic [CODE_W-1:0] b_i,
  output logic [CODE_W-1:0] min_o
);
  assign min_o = (a_i < b_i) ? a_i : b_i;
endmodule

// File: rtl/ssq_softstart.sv
module ssq_softstart #(
  parameter int CODE_W     = 8,
  parameter int NUM_STEPS  = 15,
  parameter int STEP_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [CODE_W-1:0] fb_code_i,
  output logic [CODE_W-1:0] ss_code_o,
  output logic [CODE_W-1:0] limit_code_o,
  output logic              done_o
);
  localparam int IW = $clog2(NUM_STEPS + 1);
  localparam logic [IW-1:0] TOP = IW'(NUM_STEPS);

  logic              ramp;
  logic              tick_en;
  logic              step;
  logic [IW-1:0]     idx_d;
  logic [CODE_W-1:0] level_d;
  logic [CODE_W-1:0] limit_d;

  assign tick_en = ramp && !start_i && !stop_i;

  ssq_tick_div #(.STEP_TICKS(STEP_TICKS)) u_div (
    .clk    (clk),
    .rst    (rst),
    .en_i   (tick_en),
    .step_o (step)
  );

  ssq_step_ctrl #(.NUM_STEPS(NUM_STEPS), .IW(IW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .stop_i  (stop_i),
    .step_i  (step),
    .ramp_o  (ramp),
    .idx_d_o (idx_d)
  );

  ssq_level_rom #(.CODE_W(CODE_W), .NUM_STEPS(NUM_STEPS), .IW(IW)) u_rom (
    .idx_i   (idx_d),
    .level_o (level_d)
  );

  ssq_min_sel #(.CODE_W(CODE_W)) u_min (
    .a_i   (level_d),
    .b_i   (fb_code_i),
    .min_o (limit_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_code_o    <= '0;
      limit_code_o <= '0;
      done_o       <= 1'b0;
    end else begin
      ss_code_o    <= level_d;
      limit_code_o <= limit_d;
      done_o       <= (idx_d == TOP);
    end
  end
endmodule

// File: rtl/ssq_softstart_chk.sv
module ssq_softstart_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              stop_i,
  input logic [CODE_W-1:0] fb_code_i,
  input logic [CODE_W-1:0] ss_code_o,
  input logic [CODE_W-1:0] limit_code_o,
  input logic              done_o
);
  localparam logic [CODE_W-1:0] FULL = {CODE_W{1'b1}};

  p_limit_min_r6: assert property (@(posedge clk) disable iff (rst)
    limit_code_o == (($past(fb_code_i) < ss_code_o) ? $past(fb_code_i) : ss_code_o));

  p_stop_clears_r7: assert property (@(posedge clk) disable iff (rst)
    stop_i |=> (ss_code_o == '0) && !done_o);

  p_start_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !stop_i) |=> (ss_code_o == '0));

  p_no_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !stop_i) |=> (ss_code_o >= $past(ss_code_o)));

  p_done_full_r5: assert property (@(posedge clk) disable iff (rst)
    done_o == (ss_code_o == FULL));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i && !stop_i) |=> done_o);
endmodule

bind ssq_softstart ssq_softstart_chk #(.CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .fb_code_i    (fb_code_i),
  .ss_code_o    (ss_code_o),
  .limit_code_o (limit_code_o),
  .done_o       (done_o)
);

// File: tb/tb_ssq_softstart.sv
module tb_ssq_softstart;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 8;
  localparam int NUM_STEPS  = 15;
  localparam int STEP_TICKS = 4;
  localparam int FULL       = 255;

  logic              clk = 1'b0;
  logic              rst;
  logic              start_i;
  logic              stop_i;
  logic [CODE_W-1:0] fb_code_i;
  logic [CODE_W-1:0] ss_code_o;
  logic [CODE_W-1:0] limit_code_o;
  logic              done_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssq_softstart #(.CODE_W(CODE_W), .NUM_STEPS(NUM_STEPS), .STEP_TICKS(STEP_TICKS)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i),
    .fb_code_i(fb_code_i), .ss_code_o(ss_code_o),
    .limit_code_o(limit_code_o), .done_o(done_o)
  );

  function automatic int exp_ss(input int n);
    int k;
    k = n / STEP_TICKS;
    if (k > NUM_STEPS) k = NUM_STEPS;
    return (k * FULL) / NUM_STEPS;
  endfunction

  function automatic int min2(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Wait one edge and settle past it.
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Drive a one-cycle pulse sampled at the next edge, then settle.
  task automatic pulse(input logic st, input logic sp);
    @(negedge clk);
    start_i = st;
    stop_i  = sp;
    tick();
    @(negedge clk);
    start_i = 1'b0;
    stop_i  = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; start_i = 1'b0; stop_i = 1'b0; fb_code_i = 8'd200;
    tick(); tick();
    chk("R1 ss", int'(ss_code_o), 0);
    chk("R1 limit", int'(limit_code_o), 0);
    chk("R1 done", int'(done_o), 0);
    @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R1 ss after release", int'(ss_code_o), 0);
  endtask

  task automatic t_idle();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      fb_code_i = 8'(i * 25);
      tick();
      chk("R9 idle ss", int'(ss_code_o), 0);
      chk("R9 idle limit", int'(limit_code_o), 0);
    end
  endtask

  // Full ramp with high feedback: staircase, duration, hold, done.
  task automatic t_full_ramp();
    @(negedge clk);
    fb_code_i = 8'd255;
    pulse(1'b1, 1'b0);
    chk("R2 start at zero", int'(ss_code_o), 0);
    for (int n = 1; n <= 80; n++) begin
      tick();
      chk("R3 step code", int'(ss_code_o), exp_ss(n));
      chk("R5 done flag", int'(done_o), (n >= NUM_STEPS * STEP_TICKS) ? 1 : 0);
      if (n == NUM_STEPS * STEP_TICKS - 1)
        chk("R4 one below full", int'(ss_code_o), 238);
      if (n == NUM_STEPS * STEP_TICKS)
        chk("R4 full at 60", int'(ss_code_o), FULL);
    end
    @(negedge clk);
    fb_code_i = 8'd100;
    tick();
    chk("R6 limit in hold", int'(limit_code_o), 100);
    chk("R5 hold", int'(ss_code_o), FULL);
  endtask

  // Feedback below ramp takes over the limit.
  task automatic t_takeover();
    @(negedge clk);
    fb_code_i = 8'd50;
    pulse(1'b1, 1'b0);
    for (int n = 1; n <= 20; n++) begin
      tick();
      chk("R6 limit min", int'(limit_code_o), min2(50, exp_ss(n)));
    end
  endtask

  task automatic t_restart();
    @(negedge clk);
    fb_code_i = 8'd255;
    pulse(1'b1, 1'b0);
    for (int n = 2; n <= 30; n++) tick();
    chk("R3 mid ramp", int'(ss_code_o), exp_ss(30));
    pulse(1'b1, 1'b0);
    chk("R8 restart zero", int'(ss_code_o), 0);
    for (int n = 2; n <= 4; n++) tick();
    chk("R8 first step dwell", int'(ss_code_o), 0);
    tick();
    chk("R8 first step", int'(ss_code_o), 17);
  endtask

  task automatic t_stop();
    pulse(1'b1, 1'b0);
    for (int n = 2; n <= 22; n++) tick();
    pulse(1'b0, 1'b1);
    chk("R7 stop clears", int'(ss_code_o), 0);
    chk("R7 stop done", int'(done_o), 0);
    for (int i = 0; i < 12; i++) tick();
    chk("R7 stays idle", int'(ss_code_o), 0);
    pulse(1'b1, 1'b1);
    chk("R7 stop beats start", int'(ss_code_o), 0);
    for (int i = 0; i < 10; i++) tick();
    chk("R7 no ramp after tie", int'(ss_code_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; stop_i = 1'b0; fb_code_i = '0;
    t_reset();
    t_idle();
    t_full_ramp();
    t_takeover();
    t_restart();
    t_stop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule